// File: doc/BRIEF.md
# LRU Stack Distance Profiler

This block observes a stream of memory block addresses and, for each cache set, keeps a fully associative recency stack ordered from most to least recently used. Every access looks for its address in the stack of its set. The depth at which the address is found selects one histogram counter, and the address then moves to the top of that stack. An address that is not found, because it is cold or was pushed out of the stack, is counted in a single overflow bin.

All sets share one array of counters. The finished histogram therefore gives the miss count of an LRU cache for every associativity up to the stack depth in one pass. That count is the sum of every bin deeper than the chosen associativity. Software or a debug path reads single bins through an index port. A separate query port returns that deep-bin sum one cycle after an associativity is presented. A synchronous clear starts a new profiling window.

Top module: `lru_reuse_profiler`

## Requirements
- R1: After reset, or in the cycle after `clear` is high, every bin reads zero and every stack is empty. `clear` takes priority over an access in the same cycle, and that access is neither counted nor inserted.
- R2: An access whose address sits at recency position k of its set's stack (k = 1 for the most recent, up to DEPTH) increments the bin at read index k-1.
- R3: An access whose address is not in its set's stack increments the overflow bin at read index DEPTH. This covers cold addresses and addresses that were evicted.
- R4: After an access, the accessed address holds the most recent position of its set. Entries that were above its old position each move one place deeper, and the entries below it keep their places. When the address was absent, every entry moves one place deeper and the least recent entry is dropped. An address is never held twice in one stack.
- R5: The set index is the low SET_BITS bits of the address. An access changes only the stack of its own set, while every set updates the same shared bins.
- R6: A bin at its maximum value 2^CNT_W-1 stays there on further increments.
- R7: One cycle after `q_assoc` = A is presented, `q_misses` equals the sum of the bins at read index A through DEPTH. A = 0 gives the sum of all bins, and any A above DEPTH is treated as DEPTH.
- R8: An access is accepted in every cycle that `acc_valid` is high, so back-to-back accesses are each counted. A query presented in the same cycle as an access returns sums from before that access. With no access and no clear, the bins and stacks hold.
- R9: `rd_count` shows the bin at `rd_idx` in the same cycle, and it reads zero for any index above DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of bins and stacks |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Block address of the access |
| rd_idx | input | $clog2(DEPTH+1) | Bin index to read |
| rd_count | output | CNT_W | Value of the selected bin |
| q_assoc | input | $clog2(DEPTH+1) | Associativity to evaluate |
| q_misses | output | CNT_W+$clog2(DEPTH+1) | Registered miss count for `q_assoc` |

## Verification
An access and a miss-count query can land in the same cycle. The query must then report the histogram as it stood before that access is binned. The bench provokes this by raising `acc_valid` and presenting `q_assoc` on the same clock edge. It compares `q_misses` with sums that a bench-side recency model computed before it applied the access, and then checks the bins afterwards to confirm that the access was still counted. A clear raised together with an access is judged the same way: every bin must read zero, and the next access to that address must count as cold.

// File: rtl/lru_reuse_profiler.sv
module lru_reuse_profiler #(
  parameter int ADDR_W   = 12,
  parameter int DEPTH    = 8,
  parameter int SET_BITS = 1,
  parameter int CNT_W    = 16,
  localparam int NSETS   = 1 << SET_BITS,
  localparam int IW      = $clog2(DEPTH + 1),
  localparam int SW      = CNT_W + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [IW-1:0]     rd_idx,
  output logic [CNT_W-1:0]  rd_count,
  input  logic [IW-1:0]     q_assoc,
  output logic [SW-1:0]     q_misses
);

  logic [NSETS-1:0][DEPTH-1:0][ADDR_W-1:0] tag_q;
  logic [NSETS-1:0][DEPTH-1:0]             vld_q;
  logic [DEPTH:0][CNT_W-1:0]               cnt_q;

  logic [SET_BITS-1:0] set_i;
  logic [DEPTH-1:0]    match;
  logic                hit;
  logic [IW-1:0]       hit_pos;
  logic [IW-1:0]       bump_idx;
  logic [IW-1:0]       a_eff;
  logic [SW-1:0]       deep_sum;

  assign set_i    = acc_addr[SET_BITS-1:0];
  assign bump_idx = hit ? hit_pos : IW'(DEPTH);
  assign a_eff    = (int'(q_assoc) > DEPTH) ? IW'(DEPTH) : q_assoc;
  assign rd_count = (int'(rd_idx) <= DEPTH) ? cnt_q[rd_idx] : '0;

  always_comb begin
    hit     = 1'b0;
    hit_pos = IW'(DEPTH);
    for (int i = 0; i < DEPTH; i++)
      match[i] = vld_q[set_i][i] && (tag_q[set_i][i] == acc_addr);
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match[i]) begin
        hit     = 1'b1;
        hit_pos = IW'(i);
      end
  end

  always_comb begin
    deep_sum = '0;
    for (int j = 0; j <= DEPTH; j++)
      if (j >= int'(a_eff)) deep_sum = deep_sum + SW'(cnt_q[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      vld_q <= '0;
    end else if (clear) begin
      vld_q <= '0;
    end else if (acc_valid) begin
      for (int i = 1; i < DEPTH; i++)
        if (!hit || i <= int'(hit_pos)) begin
          tag_q[set_i][i] <= tag_q[set_i][i-1];
          vld_q[set_i][i] <= vld_q[set_i][i-1];
        end
      tag_q[set_i][0] <= acc_addr;
      vld_q[set_i][0] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (acc_valid && (cnt_q[bump_idx] != '1))
      cnt_q[bump_idx] <= cnt_q[bump_idx] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_misses <= '0;
    else        q_misses <= deep_sum;
  end

endmodule

// File: rtl/lru_reuse_profiler_chk.sv
module lru_reuse_profiler_chk #(
  parameter int ADDR_W   = 12,
  parameter int DEPTH    = 8,
  parameter int SET_BITS = 1,
  parameter int CNT_W    = 16,
  localparam int NSETS   = 1 << SET_BITS,
  localparam int IW      = $clog2(DEPTH + 1),
  localparam int SW      = CNT_W + IW
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    clear,
  input logic                                    acc_valid,
  input logic [ADDR_W-1:0]                       acc_addr,
  input logic [DEPTH-1:0]                        match,
  input logic [NSETS-1:0][DEPTH-1:0][ADDR_W-1:0] tag_q,
  input logic [NSETS-1:0][DEPTH-1:0]             vld_q,
  input logic [DEPTH:0][CNT_W-1:0]               cnt_q
);

  logic [SET_BITS-1:0] sel;
  logic [SW-1:0]       total;

  assign sel = acc_addr[SET_BITS-1:0];

  always_comb begin
    total = '0;
    for (int j = 0; j <= DEPTH; j++) total = total + SW'(cnt_q[j]);
  end

  p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0) && (vld_q == '0));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !clear) |=> (total >= $past(total)) && (total <= $past(total) + 1'b1));

  p_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $onehot0(match));

  p_mru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !clear) |=> (tag_q[$past(sel)][0] == $past(acc_addr)) && vld_q[$past(sel)][0]);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !clear) |=> $stable(cnt_q) && $stable(vld_q) && $stable(tag_q));

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    p_other_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !clear && (int'(sel) != s)) |=> $stable(tag_q[s]) && $stable(vld_q[s]));
  end

  for (genvar j = 0; j <= DEPTH; j++) begin : g_bin
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> cnt_q[j] >= $past(cnt_q[j]));
  end

endmodule

bind lru_reuse_profiler lru_reuse_profiler_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SET_BITS(SET_BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .match(match), .tag_q(tag_q), .vld_q(vld_q), .cnt_q(cnt_q)
);

// File: tb/tb_lru_reuse_profiler.sv
`timescale 1ns/1ps
module tb_lru_reuse_profiler;
  localparam int ADDR_W = 8, DEPTH = 8, SET_BITS = 1, CNT_W = 6;
  localparam int IW = $clog2(DEPTH + 1), SW = CNT_W + IW;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, clear = 0, acc_valid = 0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [IW-1:0] rd_idx = '0, q_assoc = '0;
  logic [CNT_W-1:0] rd_count;
  logic [SW-1:0] q_misses;

  int nchk = 0, nerr = 0;
  int mtag[2][DEPTH];
  bit mvld[2][DEPTH];
  int mcnt[DEPTH+1];

  always #2 clk = ~clk;

  lru_reuse_profiler #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SET_BITS(SET_BITS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .rd_idx(rd_idx), .rd_count(rd_count), .q_assoc(q_assoc), .q_misses(q_misses));

  task automatic check(string req, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic m_clear();
    for (int s = 0; s < 2; s++) for (int i = 0; i < DEPTH; i++) begin mvld[s][i] = 0; mtag[s][i] = 0; end
    for (int j = 0; j <= DEPTH; j++) mcnt[j] = 0;
  endtask

  task automatic m_access(int a);
    int s = a % 2;
    int p = -1;
    int idx, lim;
    for (int i = 0; i < DEPTH; i++) if (p < 0 && mvld[s][i] && mtag[s][i] == a) p = i;
    idx = (p < 0) ? DEPTH : p;
    if (mcnt[idx] < CMAX) mcnt[idx]++;
    lim = (p < 0) ? DEPTH - 1 : p;
    for (int i = lim; i > 0; i--) begin mtag[s][i] = mtag[s][i-1]; mvld[s][i] = mvld[s][i-1]; end
    mtag[s][0] = a; mvld[s][0] = 1;
  endtask

  function automatic int m_sum(int a);
    int ae = (a > DEPTH) ? DEPTH : a;
    int t = 0;
    for (int j = ae; j <= DEPTH; j++) t += mcnt[j];
    return t;
  endfunction

  task automatic sweep_bins();
    for (int k = 0; k < 16; k++) begin
      rd_idx = IW'(k);
      #0.2;
      if (k < DEPTH) check("R2", int'(rd_count), mcnt[k]);
      else if (k == DEPTH) check("R3", int'(rd_count), mcnt[DEPTH]);
      else check("R9", int'(rd_count), 0);
    end
  endtask

  task automatic sweep_query();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk) q_assoc = IW'(a);
      @(negedge clk) check("R7", int'(q_misses), m_sum(a));
    end
  endtask

  task automatic access(int a);
    @(negedge clk) begin acc_valid = 1; acc_addr = ADDR_W'(a); end
    @(negedge clk) acc_valid = 0;
    m_access(a);
  endtask

  task automatic burst(int base, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin acc_valid = 1; acc_addr = ADDR_W'((base + i * 5) % 22); end
      if (i > 0) m_access((base + (i - 1) * 5) % 22);
    end
    @(negedge clk) acc_valid = 0;
    m_access((base + (n - 1) * 5) % 22);
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1;
    @(negedge clk) clear = 0;
    m_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int x;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    sweep_bins();
    @(negedge clk) q_assoc = '0;
    @(negedge clk) check("R1", int'(q_misses), 0);

    // R2 R3 R4: A B C B A in set 0
    access(2); access(4); access(6); access(4); access(2);
    rd_idx = 1; #0.2 check("R2", int'(rd_count), 1);
    rd_idx = 2; #0.2 check("R2", int'(rd_count), 1);
    rd_idx = IW'(DEPTH); #0.2 check("R3", int'(rd_count), 3);

    // R5: interleaved other-set accesses do not deepen set 0
    access(3); access(5); access(2);
    rd_idx = 0; #0.2 check("R5", int'(rd_count), 1);

    // R4 eviction: nine distinct in set 0 then revisit the first
    do_clear();
    for (int i = 0; i < 9; i++) access(10 + 2 * i);
    access(10);
    rd_idx = IW'(DEPTH); #0.2 check("R4", int'(rd_count), 10);
    access(14);
    rd_idx = 7; #0.2 check("R4", int'(rd_count), 1);
    sweep_bins();

    // pseudo-random stream with periodic full sweeps
    do_clear();
    x = 7;
    for (int k = 0; k < 240; k++) begin
      x = (x * 13 + 11) % 97;
      access(x % 22);
      if (k % 6 == 0) sweep_bins();
      if (k % 40 == 0) sweep_query();
    end
    sweep_bins();
    sweep_query();

    // R8 back-to-back bursts
    do_clear();
    burst(0, 30);
    sweep_bins();
    burst(3, 17);
    sweep_bins();
    sweep_query();

    // R8 access and query in the same cycle
    for (int a = 0; a < 10; a++) begin
      int exp_q;
      exp_q = m_sum(a);
      @(negedge clk) begin acc_valid = 1; acc_addr = ADDR_W'(a * 3 % 22); q_assoc = IW'(a); end
      @(negedge clk) begin acc_valid = 0; check("R8", int'(q_misses), exp_q); end
      m_access(a * 3 % 22);
      sweep_bins();
    end

    // R6 saturation
    do_clear();
    access(9);
    for (int i = 0; i < CMAX + 10; i++) access(9);
    rd_idx = 0; #0.2 check("R6", int'(rd_count), CMAX);
    sweep_bins();

    // R1 clear wins over same-cycle access
    @(negedge clk) begin clear = 1; acc_valid = 1; acc_addr = 9; end
    @(negedge clk) begin clear = 0; acc_valid = 0; end
    m_clear();
    rd_idx = 0; #0.2 check("R1", int'(rd_count), 0);
    sweep_bins();
    access(9);
    rd_idx = IW'(DEPTH); #0.2 check("R1", int'(rd_count), 1);
    rd_idx = 0; #0.2 check("R1", int'(rd_count), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule